// File: doc/BRIEF.md
# Shadowed Bus-Side Real-Time Clock

This peripheral keeps wall-clock time for a chip. A 32-bit seconds counter and a 0..999 milliseconds counter advance from a slow timebase: one pulse per period of a 32.768 kHz oscillator, presented as a single-cycle strobe in the bus clock domain. A fractional accumulator turns the 32768 pulses of each second into exactly 1000 millisecond steps.

Software does not see the live counters. Every eighth slow pulse the counters are copied into bus-visible view registers. During the slow period just before that copy, a busy flag is raised, and any register write made then is discarded. Software waits for busy to drop before it writes. Reading the milliseconds view also captures the seconds view into a shadow register, so a milliseconds read followed by a shadow read gives a matched pair.

Two seconds comparators and one milliseconds comparator set sticky status bits. The status bits are masked into a single level interrupt and cleared by writing ones.

Top module: `shadow_rtc`

## Requirements
- R1: After synchronous reset every register reads zero, busy reads 0 and `irq_o` is low.
- R2: After n slow pulses since the last seconds load, the live milliseconds value is floor(n*1000/32768) mod 1000. Seconds equal the loaded value plus floor(n*1000/32768)/1000, modulo 2^32.
- R3: The seconds view (0x08) and the milliseconds view (0x10, bits [9:0]) take the live values on every 8th slow pulse counted from reset. Otherwise they hold, except when a seconds load occurs.
- R4: Busy (0x04, bit 0) reads 1 exactly while 7 slow pulses have passed since the last copy, and 0 otherwise.
- R5: A read of 0x10 copies the current seconds view into the shadow register, which is read at 0x0C.
- R6: A write issued while busy is 1 changes no register and no counter.
- R7: An accepted write to 0x08 loads the seconds counter and the seconds view. It also zeroes the milliseconds counter, the milliseconds view and the fractional accumulator.
- R8: Two seconds alarm registers exist: alarm A at 0x14 and alarm B at 0x18. Status bit 0 (alarm A) or bit 1 (alarm B) is set when the seconds counter steps to that register's value. A value of zero disables that alarm.
- R9: The milliseconds alarm is at 0x1C, bits [9:0]. Status bit 2 is set when the milliseconds counter steps to this value.
- R10: Status (0x2C) bits clear when a one is written to them. Bits 3 and 4 are never set. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: `irq_o` is the OR of status AND mask, where the mask is at 0x28, bits [4:0]. It stays high until the active bits are cleared or masked.
- R12: Read data appears on `bus_rdata` one cycle after `bus_rd`. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per slow-oscillator period |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situations to reach from the ports are the seconds alarms and the seconds wrap. Each needs a full 32768 slow pulses between stimulus and effect. The bench drives the strobe on every cycle for those stretches, with a load value placed one second before the target.

Dropped writes only happen in the one slow period out of eight where busy is high. The bench steps pulse by pulse until its own model predicts busy, then writes. Random bursts of pulses, reads and writes also land in that window often, and a model tracks the phase to decide whether each write took effect.

// File: rtl/rtc_pkg.sv
// Package: register offsets and interrupt bit positions shared by the
// clock peripheral. Assumes byte addressing with 32-bit registers.
package rtc_pkg;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned NUM_IRQ = 5;

    localparam logic [7:0] OFF_BUSY   = 8'h04;
    localparam logic [7:0] OFF_SEC    = 8'h08;
    localparam logic [7:0] OFF_SHADOW = 8'h0C;
    localparam logic [7:0] OFF_MS     = 8'h10;
    localparam logic [7:0] OFF_ALM_A  = 8'h14;
    localparam logic [7:0] OFF_ALM_B  = 8'h18;
    localparam logic [7:0] OFF_MALM   = 8'h1C;
    localparam logic [7:0] OFF_MASK   = 8'h28;
    localparam logic [7:0] OFF_STAT   = 8'h2C;

    typedef enum int unsigned {
        IRQ_SEC_A  = 0,
        IRQ_SEC_B  = 1,
        IRQ_MS     = 2,
        IRQ_SEC_CD = 3,
        IRQ_MS_CD  = 4
    } irq_bit_e;
endpackage

// File: rtl/rtc_timebase.sv
// Module: live seconds/milliseconds counters.
// A fractional accumulator adds MS_PER_S per slow pulse and steps the
// milliseconds counter whenever it passes TICK_HZ.
// Assumes MS_PER_S < TICK_HZ, so there is at most one millisecond step per pulse.
// A load has priority over a pulse in the same cycle.
module rtc_timebase #(
    parameter int unsigned TICK_HZ  = 32768,
    parameter int unsigned MS_PER_S = 1000,
    parameter int unsigned SEC_W    = 32,
    parameter int unsigned MS_W     = $clog2(MS_PER_S)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    output logic [SEC_W-1:0] sec_cnt,
    output logic [MS_W-1:0]  ms_cnt,
    output logic             ms_step,
    output logic             sec_step,
    output logic [SEC_W-1:0] sec_nxt,
    output logic [MS_W-1:0]  ms_nxt
);
    localparam int unsigned ACC_W = $clog2(TICK_HZ) + 1;
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_S - 1);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] acc_nxt;
    logic             carry;

    // Purpose: next accumulator value and the step strobes.
    always_comb begin
        acc_sum  = acc + ACC_W'(MS_PER_S);
        carry    = (acc_sum >= ACC_W'(TICK_HZ));
        acc_nxt  = carry ? (acc_sum - ACC_W'(TICK_HZ)) : acc_sum;
        ms_step  = tick && carry && !load;
        sec_step = ms_step && (ms_cnt == MS_LAST);
        ms_nxt   = (ms_cnt == MS_LAST) ? '0 : ms_cnt + MS_W'(1);
        sec_nxt  = sec_cnt + SEC_W'(1);
    end

    // Purpose: counter registers with load priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            ms_cnt  <= '0;
            sec_cnt <= '0;
        end else if (load) begin
            acc     <= '0;
            ms_cnt  <= '0;
            sec_cnt <= load_val;
        end else if (tick) begin
            acc <= acc_nxt;
            if (ms_step)  ms_cnt  <= ms_nxt;
            if (sec_step) sec_cnt <= sec_nxt;
        end
    end

    p_ms_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt < MS_W'(MS_PER_S));
    p_sec_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sec_step |=> (sec_cnt == $past(sec_cnt) + SEC_W'(1)) && (ms_cnt == '0));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(sec_cnt) && $stable(ms_cnt));
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sec_cnt == $past(load_val)) && (ms_cnt == '0));
endmodule

// File: rtl/rtc_xfer.sv
// Module: bus-visible copy of the counters, the busy phase and the shadow.
// Counts slow pulses in a PHASE_W-bit phase. Busy is high in the last phase.
// The pulse that ends that phase copies the post-update counter values.
// Assumes load never coincides with busy (the top gates writes).
module rtc_xfer #(
    parameter int unsigned PHASE_W = 3,
    parameter int unsigned SEC_W   = 32,
    parameter int unsigned MS_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [SEC_W-1:0] load_val,
    input  logic [SEC_W-1:0] sec_in,
    input  logic [MS_W-1:0]  ms_in,
    input  logic             ms_rd,
    output logic             busy,
    output logic [SEC_W-1:0] sec_view,
    output logic [MS_W-1:0]  ms_view,
    output logic [SEC_W-1:0] shadow
);
    localparam logic [PHASE_W-1:0] PH_LAST = '1;

    logic [PHASE_W-1:0] phase;
    logic               copy;

    assign busy = (phase == PH_LAST);
    assign copy = tick && busy;

    // Purpose: slow-pulse phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    phase <= '0;
        else if (tick) phase <= phase + PHASE_W'(1);
    end

    // Purpose: view registers, reloaded by a seconds load or a copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_view <= '0;
            ms_view  <= '0;
        end else if (load) begin
            sec_view <= load_val;
            ms_view  <= '0;
        end else if (copy) begin
            sec_view <= sec_in;
            ms_view  <= ms_in;
        end
    end

    // Purpose: shadow seconds captured by a milliseconds read.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= '0;
        else if (ms_rd) shadow <= sec_view;
    end

    p_view_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!copy && !load) |=> $stable(sec_view) && $stable(ms_view));
    p_shadow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ms_rd |=> (shadow == $past(sec_view)));
    p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick) |=> !busy);
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (busy == $past(busy)));
endmodule

// File: rtl/rtc_irq.sv
// Module: sticky status bits with write-one-to-clear, and the masked level interrupt.
// A set has priority over a clear of the same bit in the same cycle.
module rtc_irq #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status,
    output logic         irq
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_vec : '0;
    assign irq     = |(status & mask);

    // Purpose: status update, with set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_eff) | set_vec;
    end

    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status & $past(clr_vec & ~set_vec)) == '0));
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));
    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_we) |=> (irq || (mask != $past(mask))));
endmodule

// File: rtl/shadow_rtc.sv
// Module: top of the memory-mapped clock.
// Decodes the register bus and gates every write while busy.
// Holds the alarm and mask registers, drives the comparators and muxes read data.
// Assumes tick_i is a one-cycle strobe already in the clk domain.
module shadow_rtc #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned TICK_HZ  = 32768,
    parameter int unsigned MS_PER_S = 1000,
    parameter int unsigned PHASE_W  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o
);
    import rtc_pkg::*;

    localparam int unsigned SEC_W = REG_W;
    localparam int unsigned MS_W  = $clog2(MS_PER_S);

    logic             busy, wr_ok;
    logic             we_sec, we_alm_a, we_alm_b, we_malm, we_mask, we_stat, rd_ms;
    logic [SEC_W-1:0] sec_cnt, sec_nxt, sec_upd, sec_view, shadow;
    logic [MS_W-1:0]  ms_cnt, ms_nxt, ms_upd, ms_view;
    logic             ms_step, sec_step;
    logic [SEC_W-1:0] alm_a, alm_b;
    logic [MS_W-1:0]  malm;
    logic [NUM_IRQ-1:0] mask, status, set_vec;
    logic [31:0]      rd_mux;
    logic             mapped;

    // Purpose: write gating and per-register strobes.
    always_comb begin
        wr_ok    = bus_wr && !busy;
        we_sec   = wr_ok && (bus_addr == ADDR_W'(OFF_SEC));
        we_alm_a = wr_ok && (bus_addr == ADDR_W'(OFF_ALM_A));
        we_alm_b = wr_ok && (bus_addr == ADDR_W'(OFF_ALM_B));
        we_malm  = wr_ok && (bus_addr == ADDR_W'(OFF_MALM));
        we_mask  = wr_ok && (bus_addr == ADDR_W'(OFF_MASK));
        we_stat  = wr_ok && (bus_addr == ADDR_W'(OFF_STAT));
        rd_ms    = bus_rd && (bus_addr == ADDR_W'(OFF_MS));
    end

    rtc_timebase #(
        .TICK_HZ (TICK_HZ),
        .MS_PER_S(MS_PER_S),
        .SEC_W   (SEC_W),
        .MS_W    (MS_W)
    ) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .load    (we_sec),
        .load_val(bus_wdata),
        .sec_cnt (sec_cnt),
        .ms_cnt  (ms_cnt),
        .ms_step (ms_step),
        .sec_step(sec_step),
        .sec_nxt (sec_nxt),
        .ms_nxt  (ms_nxt)
    );

    // Purpose: counter values as they will be after this edge.
    always_comb begin
        sec_upd = sec_step ? sec_nxt : sec_cnt;
        ms_upd  = ms_step  ? ms_nxt  : ms_cnt;
    end

    rtc_xfer #(
        .PHASE_W(PHASE_W),
        .SEC_W  (SEC_W),
        .MS_W   (MS_W)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_i),
        .load    (we_sec),
        .load_val(bus_wdata),
        .sec_in  (sec_upd),
        .ms_in   (ms_upd),
        .ms_rd   (rd_ms),
        .busy    (busy),
        .sec_view(sec_view),
        .ms_view (ms_view),
        .shadow  (shadow)
    );

    // Purpose: alarm and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_a <= '0;
            alm_b <= '0;
            malm  <= '0;
            mask  <= '0;
        end else begin
            if (we_alm_a) alm_a <= bus_wdata;
            if (we_alm_b) alm_b <= bus_wdata;
            if (we_malm)  malm  <= bus_wdata[MS_W-1:0];
            if (we_mask)  mask  <= bus_wdata[NUM_IRQ-1:0];
        end
    end

    // Purpose: comparator events on counter steps; countdown sources stay idle.
    always_comb begin
        set_vec            = '0;
        set_vec[IRQ_SEC_A] = sec_step && (alm_a != '0) && (sec_nxt == alm_a);
        set_vec[IRQ_SEC_B] = sec_step && (alm_b != '0) && (sec_nxt == alm_b);
        set_vec[IRQ_MS]    = ms_step && (ms_nxt == malm);
    end

    rtc_irq #(
        .N(NUM_IRQ)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(set_vec),
        .clr_we (we_stat),
        .clr_vec(bus_wdata[NUM_IRQ-1:0]),
        .mask   (mask),
        .status (status),
        .irq    (irq_o)
    );

    // Purpose: read data selection.
    always_comb begin
        rd_mux = '0;
        mapped = 1'b1;
        case (bus_addr)
            ADDR_W'(OFF_BUSY):   rd_mux = {31'b0, busy};
            ADDR_W'(OFF_SEC):    rd_mux = sec_view;
            ADDR_W'(OFF_SHADOW): rd_mux = shadow;
            ADDR_W'(OFF_MS):     rd_mux = 32'(ms_view);
            ADDR_W'(OFF_ALM_A):  rd_mux = alm_a;
            ADDR_W'(OFF_ALM_B):  rd_mux = alm_b;
            ADDR_W'(OFF_MALM):   rd_mux = 32'(malm);
            ADDR_W'(OFF_MASK):   rd_mux = 32'(mask);
            ADDR_W'(OFF_STAT):   rd_mux = 32'(status);
            default:             mapped = 1'b0;
        endcase
    end

    // Purpose: registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && busy) |=> $stable(mask) && $stable(alm_a) && $stable(alm_b)
                             && $stable(malm) && $stable(sec_view));
    p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == '0));
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    p_cd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        status[IRQ_MS_CD:IRQ_SEC_CD] == 2'b00);
endmodule

// File: tb/shadow_rtc_test.sv
// Bench: directed corners plus seeded random bursts, checked against a
// behavioural model kept in bench variables.
module shadow_rtc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint unsigned n_ld;
    int unsigned     gticks;
    logic [31:0] m_base, m_vsec, m_shadow, m_alm_a, m_alm_b;
    logic [9:0]  m_vms, m_malm;
    logic [4:0]  m_mask, m_stat;

    always #10 clk = ~clk;

    shadow_rtc uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    function automatic longint unsigned ms_tot(longint unsigned n);
        return (n * 1000) / 32768;
    endfunction
    function automatic logic [31:0] core_sec();
        return m_base + 32'(ms_tot(n_ld) / 1000);
    endfunction
    function automatic logic [9:0] core_ms();
        return 10'(ms_tot(n_ld) % 1000);
    endfunction
    function automatic bit m_busy();
        return (gticks % 8) == 7;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic model_tick();
        longint unsigned old = ms_tot(n_ld);
        n_ld++;
        if (ms_tot(n_ld) != old) begin
            if (core_ms() == m_malm) m_stat[2] = 1'b1;
            if (core_ms() == 10'd0) begin
                if (m_alm_a != 0 && core_sec() == m_alm_a) m_stat[0] = 1'b1;
                if (m_alm_b != 0 && core_sec() == m_alm_b) m_stat[1] = 1'b1;
            end
        end
        gticks++;
        if (gticks % 8 == 0) begin
            m_vsec = core_sec();
            m_vms  = core_ms();
        end
    endtask

    task automatic run_ticks(int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            tick = 1'b1;
            model_tick();
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        if (!m_busy()) begin
            case (a)
                8'h08: begin m_base = d; n_ld = 0; m_vsec = d; m_vms = '0; end
                8'h14: m_alm_a = d;
                8'h18: m_alm_b = d;
                8'h1C: m_malm = d[9:0];
                8'h28: m_mask = d[4:0];
                8'h2C: m_stat = m_stat & ~d[4:0];
                default: ;
            endcase
        end
        @(negedge clk);
        wr = 1'b0;
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h04: return {31'b0, m_busy()};
            8'h08: return m_vsec;
            8'h0C: return m_shadow;
            8'h10: return {22'b0, m_vms};
            8'h14: return m_alm_a;
            8'h18: return m_alm_b;
            8'h1C: return {22'b0, m_malm};
            8'h28: return {27'b0, m_mask};
            8'h2C: return {27'b0, m_stat};
            default: return 32'h0;
        endcase
    endfunction

    task automatic read_chk(string tag, logic [7:0] a);
        logic [31:0] e;
        @(negedge clk);
        addr = a; rd = 1'b1;
        e = exp_read(a);
        if (a == 8'h10) m_shadow = m_vsec;
        @(negedge clk);
        rd = 1'b0;
        chk(tag, rdata, e);
    endtask

    task automatic irq_chk(string tag);
        chk(tag, {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
    endtask

    task automatic align();
        if (m_busy()) run_ticks(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] addrs [11] = '{8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                   8'h1C, 8'h28, 8'h2C, 8'h20, 8'h3C};
        int unsigned seed_v;
        seed_v = $urandom(32'd20190607);
        n_ld = 0; gticks = 0;
        m_base = 0; m_vsec = 0; m_shadow = 0; m_alm_a = 0; m_alm_b = 0;
        m_vms = 0; m_malm = 0; m_mask = 0; m_stat = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers and the interrupt
        read_chk("R1 busy", 8'h04);
        read_chk("R1 seconds", 8'h08);
        read_chk("R1 ms", 8'h10);
        read_chk("R1 shadow", 8'h0C);
        read_chk("R1 mask", 8'h28);
        read_chk("R1 status", 8'h2C);
        irq_chk("R1 irq");

        // R4, R3: busy in the last phase, views hold until the copy
        run_ticks(7);
        read_chk("R4 busy high", 8'h04);
        read_chk("R3 ms view before copy", 8'h10);
        // R6: writes while busy are dropped
        bus_write(8'h28, 32'h1F);
        read_chk("R6 mask unchanged", 8'h28);
        bus_write(8'h08, 32'hABCD);
        read_chk("R6 seconds unchanged", 8'h08);
        run_ticks(1);
        read_chk("R4 busy low after copy", 8'h04);
        run_ticks(40);
        read_chk("R2 R3 ms view", 8'h10);

        // R7: seconds load and immediate view update
        align();
        bus_write(8'h08, 32'h1234);
        read_chk("R7 seconds loaded", 8'h08);
        read_chk("R7 ms zeroed", 8'h10);

        // R5: shadow pairs with the ms read, not with a later load
        align();
        read_chk("R5 ms read", 8'h10);
        bus_write(8'h08, 32'h5555);
        read_chk("R5 shadow", 8'h0C);

        // R9, R11: ms alarm at value 5
        align();
        bus_write(8'h08, 32'd7);
        bus_write(8'h1C, 32'd5);
        bus_write(8'h28, 32'h04);
        run_ticks(163);
        irq_chk("R9 before ms alarm");
        run_ticks(1);
        irq_chk("R9 R11 ms alarm fires");
        read_chk("R9 status", 8'h2C);
        align();
        bus_write(8'h2C, 32'hFFFF_FFFF);
        irq_chk("R10 cleared");

        // R8: both seconds alarms at the next second
        align();
        bus_write(8'h08, 32'd100);
        bus_write(8'h14, 32'd101);
        bus_write(8'h18, 32'd101);
        bus_write(8'h1C, 32'd999);
        bus_write(8'h28, 32'h01);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        run_ticks(32767);
        irq_chk("R8 before second");
        run_ticks(1);
        irq_chk("R8 R11 alarm A fires");
        read_chk("R8 status bits", 8'h2C);
        align();
        bus_write(8'h2C, 32'h1);
        irq_chk("R10 clear bit 0");
        read_chk("R10 bit 1 kept", 8'h2C);

        // R2, R8: seconds wrap with both alarms disabled by zero
        align();
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'd0);
        bus_write(8'h18, 32'd0);
        bus_write(8'h2C, 32'hFFFF_FFFF);
        run_ticks(32768 + 16);
        read_chk("R2 seconds wrapped", 8'h08);
        read_chk("R8 zero alarm silent", 8'h2C);

        // R12: unmapped offset reads zero
        read_chk("R12 unmapped", 8'h20);

        // Random mix of pulse bursts, reads and writes
        for (int it = 0; it < 400; it++) begin
            int unsigned op = $urandom_range(0, 5);
            logic [7:0] a = addrs[$urandom_range(0, 10)];
            if (op < 3) run_ticks($urandom_range(1, 12));
            else if (op < 5) read_chk("R2 R3 R4 R5 R12 random read", a);
            else bus_write(a, (a == 8'h1C) ? $urandom_range(0, 999) : $urandom);
            irq_chk("R11 random irq");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule